// File: doc/BRIEF.md
# Six-Digit Time-of-Day Counter with Seven-Segment Outputs

This block keeps a 24-hour time of day as six BCD digits (hours, minutes and seconds, each split into tens and units) and drives six active-low seven-segment displays, one per digit. Every register runs on a single free-running system clock. A prescaler turns that clock into an advance enable that is high for one cycle. The digit chain moves forward by one second only on cycles where the enable is high. The slow rate never acts as a clock.

A 2-bit rate input sets the prescaler divisor. One setting gives real time. Two faster settings and a very short divisor let the same counter chain be checked quickly on a board or in simulation. A synchronous active-high reset clears the time and the prescaler.

Top module: `hms_clock`

## Requirements
- R1: In the cycle after synchronous reset is released, all six displays show digit 0, so the time reads 00:00:00.
- R2: Each display is 7 bits, active low, with bit 0 = segment a through bit 6 = segment g. The digit codes in hex are: 0=40, 1=79, 2=24, 3=30, 4=19, 5=12, 6=02, 7=78, 8=00, 9=10.
- R3: With rate_sel = 2'b11, the time advances by one second every SIM_DIV clock cycles (default 10). The first advance comes on the SIM_DIV-th rising edge after reset is released.
- R4: rate_sel = 2'b00 divides by CLK_HZ (1 Hz), 2'b01 divides by CLK_HZ/10, and 2'b10 divides by CLK_HZ/1000. In each case the first advance comes on the divisor-th edge after reset.
- R5: When rate_sel changes, the prescaler restarts from zero on the next edge. The next advance then comes a full new divisor of edges after that restart edge. Counting done before the change is lost.
- R6: The seconds units digit counts 0 to 9, and its wrap steps the seconds tens digit, which counts 0 to 5. A wrap from 59 to 00 seconds steps the minutes.
- R7: The minutes follow the same 0 to 9 and 0 to 5 pattern. A wrap from 59:59 steps the hours.
- R8: Hours count 00 to 23. 09:59:59 becomes 10:00:00, and 23:59:59 becomes 00:00:00.
- R9: The advance enable is never high in two consecutive cycles. The displayed time does not change between advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Advance rate select |
| seg_hr_tens | output | 7 | Hours tens display, active low |
| seg_hr_units | output | 7 | Hours units display, active low |
| seg_min_tens | output | 7 | Minutes tens display, active low |
| seg_min_units | output | 7 | Minutes units display, active low |
| seg_sec_tens | output | 7 | Seconds tens display, active low |
| seg_sec_units | output | 7 | Seconds units display, active low |

## Verification
The assertions check on every cycle that:
- each digit stays within its own bound and returns to zero after it wraps;
- the advance pulse lasts one cycle;
- the time holds between pulses;
- the prescaler count stays below the active divisor;
- a rate change clears that count.

Only the directed scenarios can show the things that depend on counting or decoding:
- the exact edge on which each divisor produces its first advance;
- the cost of a mid-count rate change;
- the decoded segment patterns;
- the carries at 59 seconds, at 59:59, at 09:59:59, and the full-day wrap at 23:59:59.

// File: rtl/clk6_pkg.sv
package clk6_pkg;

    typedef enum logic [1:0] {
        RATE_REAL = 2'b00,
        RATE_TENTH = 2'b01,
        RATE_MILLI = 2'b10,
        RATE_SIM = 2'b11
    } rate_e;

    localparam int UNITS_W = 4;
    localparam int TENS_W = 3;
    localparam int HTENS_W = 2;
    localparam int NUM_DIGITS = 6;
    localparam int SEG_W = 7;

    typedef struct packed {
        logic [HTENS_W-1:0] hr_t;
        logic [UNITS_W-1:0] hr_u;
        logic [TENS_W-1:0] min_t;
        logic [UNITS_W-1:0] min_u;
        logic [TENS_W-1:0] sec_t;
        logic [UNITS_W-1:0] sec_u;
    } hms_t;

    // Active-low pattern, bit 0 = segment a
    function automatic logic [SEG_W-1:0] seg_pattern(input logic [UNITS_W-1:0] val);
        logic [SEG_W-1:0] p;
        case (val)
            4'd0: p = 7'h40;
            4'd1: p = 7'h79;
            4'd2: p = 7'h24;
            4'd3: p = 7'h30;
            4'd4: p = 7'h19;
            4'd5: p = 7'h12;
            4'd6: p = 7'h02;
            4'd7: p = 7'h78;
            4'd8: p = 7'h00;
            4'd9: p = 7'h10;
            default: p = 7'h7F;
        endcase
        return p;
    endfunction

    function automatic int unsigned rate_divisor(input logic [1:0] sel,
                                                 input int unsigned clk_hz,
                                                 input int unsigned sim_div);
        int unsigned d;
        case (rate_e'(sel))
            RATE_REAL: d = clk_hz;
            RATE_TENTH: d = clk_hz / 10;
            RATE_MILLI: d = clk_hz / 1000;
            default: d = sim_div;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hms_tick_gen.sv
module hms_tick_gen
    import clk6_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned SIM_DIV = 10
) (
    input logic clk,
    input logic rst,
    input logic [1:0] rate_sel,
    output logic tick
);
    localparam int CW = $clog2(CLK_HZ + 1);

    logic [CW-1:0] cnt;
    logic [1:0] rate_q;
    logic [CW-1:0] div_now;
    logic rate_chg;
    logic at_last;

    assign div_now = CW'(rate_divisor(rate_q, CLK_HZ, SIM_DIV));
    assign rate_chg = (rate_sel != rate_q);
    assign at_last = (cnt == div_now - CW'(1));
    assign tick = at_last && !rate_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            rate_q <= rate_sel;
        end else if (rate_chg) begin
            cnt <= '0;
            rate_q <= rate_sel;
        end else if (at_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R5: a new setting clears the count
    p_restart_on_change_r5: assert property (@(posedge clk) disable iff (rst)
        rate_chg |=> (cnt == '0));

    // R4: the count never reaches the divisor
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt < div_now);

    // R9: the enable lasts a single cycle
    p_tick_single_r9: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/hms_digit.sv
module hms_digit #(
    parameter int W = 4
) (
    input logic clk,
    input logic rst,
    input logic step,
    input logic [W-1:0] last,
    output logic [W-1:0] q,
    output logic carry
);
    assign carry = step && (q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (carry) begin
            q <= '0;
        end else if (step) begin
            q <= q + W'(1);
        end
    end

    // R6: a digit stays within its bound
    p_digit_bound_r6: assert property (@(posedge clk) disable iff (rst)
        q <= last);

    // R6: after a wrap the digit reads zero
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
        carry |=> (q == '0));

endmodule

// File: rtl/hms_seg_dec.sv
module hms_seg_dec
    import clk6_pkg::*;
(
    input logic [UNITS_W-1:0] code,
    output logic [SEG_W-1:0] seg
);
    assign seg = seg_pattern(code);
endmodule

// File: rtl/hms_clock.sv
module hms_clock
    import clk6_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned SIM_DIV = 10
) (
    input logic clk,
    input logic rst,
    input logic [1:0] rate_sel,
    output logic [6:0] seg_hr_tens,
    output logic [6:0] seg_hr_units,
    output logic [6:0] seg_min_tens,
    output logic [6:0] seg_min_units,
    output logic [6:0] seg_sec_tens,
    output logic [6:0] seg_sec_units
);
    logic tick;
    hms_t now;
    logic c_su, c_st, c_mu, c_mt, c_hu, c_ht;
    logic [UNITS_W-1:0] hr_u_last;
    logic [UNITS_W-1:0] codes [NUM_DIGITS];
    logic [SEG_W-1:0] segs [NUM_DIGITS];

    hms_tick_gen #(.CLK_HZ(CLK_HZ), .SIM_DIV(SIM_DIV)) u_tick (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .tick(tick)
    );

    hms_digit #(.W(UNITS_W)) u_sec_u (
        .clk(clk), .rst(rst), .step(tick), .last(4'd9),
        .q(now.sec_u), .carry(c_su)
    );
    hms_digit #(.W(TENS_W)) u_sec_t (
        .clk(clk), .rst(rst), .step(c_su), .last(3'd5),
        .q(now.sec_t), .carry(c_st)
    );
    hms_digit #(.W(UNITS_W)) u_min_u (
        .clk(clk), .rst(rst), .step(c_st), .last(4'd9),
        .q(now.min_u), .carry(c_mu)
    );
    hms_digit #(.W(TENS_W)) u_min_t (
        .clk(clk), .rst(rst), .step(c_mu), .last(3'd5),
        .q(now.min_t), .carry(c_mt)
    );

    // Hours units stop at 3 once the tens digit reaches 2
    assign hr_u_last = (now.hr_t == 2'd2) ? 4'd3 : 4'd9;

    hms_digit #(.W(UNITS_W)) u_hr_u (
        .clk(clk), .rst(rst), .step(c_mt), .last(hr_u_last),
        .q(now.hr_u), .carry(c_hu)
    );
    hms_digit #(.W(HTENS_W)) u_hr_t (
        .clk(clk), .rst(rst), .step(c_hu), .last(2'd2),
        .q(now.hr_t), .carry(c_ht)
    );

    // Tens digits are zero-extended into the shared decoder
    assign codes[0] = {{(UNITS_W-HTENS_W){1'b0}}, now.hr_t};
    assign codes[1] = now.hr_u;
    assign codes[2] = {1'b0, now.min_t};
    assign codes[3] = now.min_u;
    assign codes[4] = {1'b0, now.sec_t};
    assign codes[5] = now.sec_u;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dec
        hms_seg_dec u_dec (.code(codes[i]), .seg(segs[i]));
    end

    assign seg_hr_tens = segs[0];
    assign seg_hr_units = segs[1];
    assign seg_min_tens = segs[2];
    assign seg_min_units = segs[3];
    assign seg_sec_tens = segs[4];
    assign seg_sec_units = segs[5];

    // R9: time holds between enables
    p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(now));

    // R8: hours never pass 23
    p_hours_range_r8: assert property (@(posedge clk) disable iff (rst)
        (now.hr_t < 2'd2) || (now.hr_u <= 4'd3));

    // R8: the day wrap clears both hour digits together
    p_day_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        c_ht |=> (now.hr_t == 2'd0 && now.hr_u == 4'd0));

endmodule

// File: tb/hms_clock_tb.sv
module hms_clock_tb;
    localparam int unsigned CLK_HZ = 2000;
    localparam int unsigned SIM_DIV = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] rate_sel = 2'b11;
    logic [6:0] s_ht, s_hu, s_mt, s_mu, s_st, s_su;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    hms_clock #(.CLK_HZ(CLK_HZ), .SIM_DIV(SIM_DIV)) u_dut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel),
        .seg_hr_tens(s_ht), .seg_hr_units(s_hu),
        .seg_min_tens(s_mt), .seg_min_units(s_mu),
        .seg_sec_tens(s_st), .seg_sec_units(s_su)
    );

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'h40;
            1: return 7'h79;
            2: return 7'h24;
            3: return 7'h30;
            4: return 7'h19;
            5: return 7'h12;
            6: return 7'h02;
            7: return 7'h78;
            8: return 7'h00;
            9: return 7'h10;
            default: return 7'h7F;
        endcase
    endfunction

    task automatic check_time(input int secs, input string tag);
        int t, h, m, s;
        logic [41:0] act, exp;
        t = secs % 86400;
        h = t / 3600;
        m = (t / 60) % 60;
        s = t % 60;
        exp = {exp_seg(h / 10), exp_seg(h % 10), exp_seg(m / 10),
               exp_seg(m % 10), exp_seg(s / 10), exp_seg(s % 10)};
        act = {s_ht, s_hu, s_mt, s_mu, s_st, s_su};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: segments %h expected %h (time %0d s)", tag, act, exp, secs);
        end
    endtask

    // Leaves the bench 1 ns after the reset-release edge
    task automatic do_reset(input logic [1:0] rate);
        rate_sel = rate;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset(2'b11);
        check_time(0, "R1 reset clears to 00:00:00");
    endtask

    task automatic t_sim_rate();
        do_reset(2'b11);
        edges(SIM_DIV - 1);
        check_time(0, "R9 no advance before tick");
        edges(1);
        check_time(1, "R3 first advance at SIM_DIV edges");
        for (int k = 2; k <= 10; k++) begin
            edges(SIM_DIV - 1);
            check_time(k - 1, "R9 hold between ticks");
            edges(1);
            check_time(k, "R2 R6 seconds units codes");
        end
    endtask

    task automatic t_rates();
        int d;
        for (int r = 0; r < 3; r++) begin
            d = (r == 0) ? CLK_HZ : (r == 1) ? CLK_HZ / 10 : CLK_HZ / 1000;
            do_reset(r[1:0]);
            edges(d - 1);
            check_time(0, "R4 divisor not yet reached");
            edges(1);
            check_time(1, "R4 advance at divisor");
        end
    endtask

    task automatic t_change();
        do_reset(2'b11);
        edges(7);
        rate_sel = 2'b01;
        edges(1 + CLK_HZ / 10 - 1);
        check_time(0, "R5 old count discarded");
        edges(1);
        check_time(1, "R5 full new divisor after restart");
    endtask

    task automatic t_day();
        do_reset(2'b10);
        edges(59 * 2);
        check_time(59, "R6 seconds reach 59");
        edges(2);
        check_time(60, "R6 seconds wrap into minutes");
        edges((3599 - 60) * 2);
        check_time(3599, "R7 00:59:59");
        edges(2);
        check_time(3600, "R7 minutes wrap into hours");
        edges((35999 - 3600) * 2);
        check_time(35999, "R8 09:59:59");
        edges(2);
        check_time(36000, "R8 hours units wrap at 9");
        edges((86399 - 36000) * 2);
        check_time(86399, "R8 23:59:59");
        edges(2);
        check_time(86400, "R8 day wrap to 00:00:00");
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_sim_rate();
        t_rates();
        t_change();
        t_day();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule